// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

A memory-mapped watchdog whose configuration is protected by a magic key. Software talks to it over a plain register bus (word address, write strobe, write data, combinational read data). Three word registers exist: control/status at word 0, the running count at word 1 and the timeout limit at word 2. Writing the open key to the count register opens a window of limited length during which control/status and the limit may be rewritten. Writing the service key to the same register restarts the count.

Keys are checked either as one 32-bit word or as two 16-bit halves written one after the other, chosen by a control bit. When the enabled count reaches the limit the block raises a flag, optionally an interrupt, and then a sticky reset request. A control write that leaves the update-permit bit clear freezes the configuration until the next hardware reset.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, control/status reads 0x00002420 (wide keys, done status, update permit set), the count reads 0, the limit reads 0xFFFF, and irq and rst_req are low.
- R2: Writing 0xD928C520 to word 1 while bit 13 is 1 sets the open status (bit 11) from the next cycle; it stays open for 255 clocks, and closes at once after an accepted control/status write.
- R3: Writes to control/status and to the limit change no stored setting unless the window is open; writing 1 to bit 14 clears the flag at any time.
- R4: With bit 13 at 0, the window opens only when the low halves 0xC520 and then 0xD928 are written to word 1 as consecutive writes, the second within 16 clocks of the first; any other value or order resets the tracker.
- R5: Writing 0xB480A602 (wide) or the halves 0xA602 then 0xB480 (narrow) to word 1 sets the count to 0 in the next cycle and restarts the prescaler.
- R6: The done status (bit 10) reads 0 after an unlock and reads 1 from the cycle after an accepted control/status write.
- R7: With enable (bit 7) set the count advances every clock, or every 256 clocks when the prescaler bit (bit 12) is set; on the tick where the count equals the limit, the flag (bit 14) sets and the count wraps to 0; irq equals flag AND interrupt-enable (bit 6).
- R8: The timeout asserts rst_req on the same edge when bit 6 is 0, or on the next count tick when bit 6 is 1; rst_req then stays high until reset.
- R9: An accepted control/status write with bit 5 clear blocks every later unlock until reset.
- R10: A service key and a timeout in the same cycle: the service wins, the count becomes 0 and no flag or reset request follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Word address: 0 control/status, 1 count/key, 2 limit |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word |
| irq | output | 1 | Timeout interrupt |
| rst_req | output | 1 | Sticky reset request |

## Verification
The interesting collision is a service key landing on exactly the tick where the count meets the limit, so that restart and timeout compete for the same edge. The bench enables the counter with a limit of 4, counts the edges after the enabling write and places the service write on the fifth one; the count must read 0 afterwards and neither flag nor rst_req may rise. A behavioural reference model, compared every clock on rdata, irq and rst_req, also judges the window expiring on the same edge as a limit write.

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
  parameter int CNT_W = 16,
  parameter int WIN_CLKS = 255,
  parameter int GAP_CLKS = 16,
  parameter int PRE_DIV = 256,
  parameter logic [CNT_W-1:0] TO_INIT = '1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        rst_req
);
  localparam int WIN_W = $clog2(WIN_CLKS + 1);
  localparam int GAP_W = $clog2(GAP_CLKS + 1);
  localparam int PRE_W = $clog2(PRE_DIV);
  localparam logic [31:0] KEY_OPEN = 32'hD928_C520;
  localparam logic [31:0] KEY_KICK = 32'hB480_A602;
  localparam logic [13:0] CFG_MASK = 14'h33E3;
  localparam logic [13:0] CFG_INIT = 14'h2020;
  localparam logic [1:0] H_IDLE = 2'd0, H_OPEN = 2'd1, H_KICK = 2'd2;

  logic [13:0]      cfg_q;
  logic [CNT_W-1:0] cnt_q, toval_q;
  logic [WIN_W-1:0] win_q;
  logic [GAP_W-1:0] gap_q;
  logic [PRE_W-1:0] div_q;
  logic [1:0]       half_q;
  logic             flag_q, done_q, frozen_q, pend_q, rst_q;

  logic wide, pre, en, ie;
  assign wide = cfg_q[13];
  assign pre  = cfg_q[12];
  assign en   = cfg_q[7];
  assign ie   = cfg_q[6];

  logic wr_cs, wr_cnt, wr_to;
  assign wr_cs  = wr_en && addr == 2'd0;
  assign wr_cnt = wr_en && addr == 2'd1;
  assign wr_to  = wr_en && addr == 2'd2;

  logic [15:0] lo;
  assign lo = wdata[15:0];

  logic open_key, kick_key, unlock, kick, open_st, cs_ok, to_ok, tick, hit;
  assign open_key = wide ? (wdata == KEY_OPEN) : (half_q == H_OPEN && lo == KEY_OPEN[31:16]);
  assign kick_key = wide ? (wdata == KEY_KICK) : (half_q == H_KICK && lo == KEY_KICK[31:16]);
  assign unlock   = wr_cnt && open_key && !frozen_q;
  assign kick     = wr_cnt && kick_key;
  assign open_st  = win_q != '0;
  assign cs_ok    = wr_cs && open_st;
  assign to_ok    = wr_to && open_st;
  assign tick     = en && (!pre || div_q == PRE_W'(PRE_DIV - 1));
  assign hit      = tick && !kick && cnt_q == toval_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= H_IDLE;
      gap_q  <= '0;
    end else if (wr_cnt) begin
      gap_q <= '0;
      if (!wide && lo == KEY_OPEN[15:0])      half_q <= H_OPEN;
      else if (!wide && lo == KEY_KICK[15:0]) half_q <= H_KICK;
      else                                    half_q <= H_IDLE;
    end else if (half_q != H_IDLE) begin
      if (gap_q == GAP_W'(GAP_CLKS - 1)) begin
        half_q <= H_IDLE;
        gap_q  <= '0;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= '0;
      done_q   <= 1'b1;
      frozen_q <= 1'b0;
      cfg_q    <= CFG_INIT;
      toval_q  <= TO_INIT;
    end else begin
      if (unlock)           win_q <= WIN_W'(WIN_CLKS);
      else if (cs_ok)       win_q <= '0;
      else if (open_st)     win_q <= win_q - 1'b1;
      if (unlock)           done_q <= 1'b0;
      else if (cs_ok)       done_q <= 1'b1;
      if (cs_ok) begin
        cfg_q <= wdata[13:0] & CFG_MASK;
        if (!wdata[5]) frozen_q <= 1'b1;
      end
      if (to_ok)            toval_q <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      div_q  <= '0;
      flag_q <= 1'b0;
      pend_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (kick || hit)  cnt_q <= '0;
      else if (tick)    cnt_q <= cnt_q + 1'b1;
      if (!en || kick || div_q == PRE_W'(PRE_DIV - 1)) div_q <= '0;
      else              div_q <= div_q + 1'b1;
      if (hit)                     flag_q <= 1'b1;
      else if (wr_cs && wdata[14]) flag_q <= 1'b0;
      if (hit && ie)    pend_q <= 1'b1;
      if ((hit && !ie) || (pend_q && tick)) rst_q <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {17'b0, flag_q, cfg_q[13:12], open_st, done_q, cfg_q[9:0]};
      2'd1:    rdata = {{(32-CNT_W){1'b0}}, cnt_q};
      2'd2:    rdata = {{(32-CNT_W){1'b0}}, toval_q};
      default: rdata = '0;
    endcase
  end

  assign irq     = flag_q && ie;
  assign rst_req = rst_q;
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             unlock,
  input logic             kick,
  input logic             open_st,
  input logic             frozen_q,
  input logic [13:0]      cfg_q,
  input logic [CNT_W-1:0] toval_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             flag_q,
  input logic             rst_req
);
  p_unlock_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> open_st);

  p_closed_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !open_st |=> $stable(toval_q));

  p_service_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> cnt_q == '0);

  p_flag_at_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(cnt_q) == $past(toval_q));

  p_reset_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  p_direct_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q) && !$past(cfg_q[6])) |-> rst_req);

  p_frozen_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_q |=> $stable(cfg_q));

  p_service_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !$rose(flag_q));
endmodule

bind keyed_wdog keyed_wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .unlock(unlock), .kick(kick), .open_st(open_st),
  .frozen_q(frozen_q), .cfg_q(cfg_q), .toval_q(toval_q), .cnt_q(cnt_q),
  .flag_q(flag_q), .rst_req(rst_req)
);

// File: tb/tb_keyed_wdog.sv
module tb_keyed_wdog;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, rst_req;

  int checks = 0, errors = 0;
  bit live = 0;

  keyed_wdog dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
                  .rdata(rdata), .irq(irq), .rst_req(rst_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_cfg, m_to, m_cnt, m_div, m_win, m_gap, m_half;
  bit m_flag, m_done, m_frz, m_pend, m_rst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 'h2020; m_to = 'hFFFF; m_cnt = 0; m_div = 0; m_win = 0; m_gap = 0; m_half = 0;
      m_flag = 0; m_done = 1; m_frz = 0; m_pend = 0; m_rst = 0;
    end else begin
      bit wcs, wcn, wto, wide, en, ie, pre, okey, kkey, unl, op, tick, hit;
      int lo;
      wcs = wr_en && addr == 0; wcn = wr_en && addr == 1; wto = wr_en && addr == 2;
      wide = m_cfg[13]; pre = m_cfg[12]; en = m_cfg[7]; ie = m_cfg[6];
      lo = wdata[15:0];
      okey = wcn && (wide ? wdata == 32'hD928C520 : (m_half == 1 && lo == 'hD928));
      kkey = wcn && (wide ? wdata == 32'hB480A602 : (m_half == 2 && lo == 'hB480));
      unl = okey && !m_frz;
      op = m_win > 0;
      tick = en && (!pre || m_div == 255);
      hit = tick && !kkey && m_cnt == m_to;
      if ((hit && !ie) || (m_pend && tick)) m_rst = 1;
      if (hit && ie) m_pend = 1;
      if (hit) m_flag = 1; else if (wcs && wdata[14]) m_flag = 0;
      if (kkey || hit) m_cnt = 0; else if (tick) m_cnt = (m_cnt + 1) % 65536;
      if (!en || kkey) m_div = 0; else m_div = (m_div + 1) % 256;
      if (unl) begin m_win = 255; m_done = 0; end
      else if (wcs && op) m_win = 0;
      else if (m_win > 0) m_win = m_win - 1;
      if (wcs && op) begin
        m_cfg = wdata & 'h33E3; m_done = 1;
        if (!wdata[5]) m_frz = 1;
      end
      if (wto && op) m_to = wdata[15:0];
      if (wcn) begin
        m_gap = 0;
        m_half = wide ? 0 : (lo == 'hC520) ? 1 : (lo == 'hA602) ? 2 : 0;
      end else if (m_half != 0) begin
        if (m_gap == 15) begin m_half = 0; m_gap = 0; end
        else m_gap = m_gap + 1;
      end
    end
  end

  function automatic logic [31:0] model_read(logic [1:0] a);
    case (a)
      2'd0: return (32'(m_flag) << 14) | (32'(m_win > 0) << 11) | (32'(m_done) << 10) | 32'(m_cfg);
      2'd1: return 32'(m_cnt);
      2'd2: return 32'(m_to);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n) begin
      chk("R3 model rdata", rdata, model_read(addr));
      chk("R7 model irq", 32'(irq), 32'(m_cfg[6] && m_flag));
      chk("R8 model rst_req", 32'(rst_req), 32'(m_rst));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
    #1; addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired (R1..run)");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; live = 1;
    // R1 reset state
    rd("R1 cs", 0, 32'h2420);
    rd("R1 count", 1, 0);
    rd("R1 limit", 2, 32'hFFFF);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rst_req", 32'(rst_req), 0);
    // R3 locked writes ignored
    wr(2, 5);
    rd("R3 limit locked", 2, 32'hFFFF);
    wr(0, 32'h20A0);
    rd("R3 cs locked", 0, 32'h2420);
    // R2 wide unlock, R6 done cleared
    wr(1, 32'hD928C520);
    rd("R2 R6 open", 0, 32'h2820);
    wr(2, 20);
    rd("R3 limit open", 2, 20);
    wr(0, 32'h20A0);
    rd("R2 R6 closed and done", 0, 32'h24A0);
    repeat (5) @(posedge clk);
    wr(1, 32'hB480A602);
    rd("R5 wide service", 1, 0);
    // R7 R8 timeout without interrupt enable
    repeat (20) @(posedge clk);
    rd("R8 not yet", 3, 0);
    chk("R8 before limit", 32'(rst_req), 0);
    @(posedge clk);
    rd("R7 flag set", 0, 32'h64A0);
    chk("R8 immediate", 32'(rst_req), 1);
    chk("R7 no irq when disabled", 32'(irq), 0);

    // R4 narrow keys, R5 narrow service
    do_reset();
    wr(1, 32'hD928C520);
    wr(0, 32'h00A0);
    rd("R4 narrow cfg", 0, 32'h04A0);
    wr(1, 32'hD928); wr(1, 32'hC520);
    rd("R4 wrong order", 0, 32'h04A0);
    wr(1, 32'hC520); repeat (20) @(posedge clk); wr(1, 32'hD928);
    rd("R4 gap too long", 0, 32'h04A0);
    wr(1, 32'hC520); wr(1, 32'h1234); wr(1, 32'hD928);
    rd("R4 interrupted", 0, 32'h04A0);
    wr(1, 32'hC520); repeat (14) @(posedge clk); wr(1, 32'hD928);
    rd("R4 gap boundary accepted", 0, 32'h08A0);
    wr(0, 32'h00A0);
    wr(1, 32'hC520); wr(1, 32'hD928);
    rd("R4 narrow open", 0, 32'h08A0);
    wr(1, 32'hA602); wr(1, 32'hB480);
    rd("R5 narrow service", 1, 0);

    // R7 prescaler, interrupt path, W1C, R8 delayed
    do_reset();
    wr(1, 32'hD928C520);
    wr(2, 1);
    wr(0, 32'h10E0);
    repeat (255) @(posedge clk);
    rd("R7 prescaled hold", 1, 0);
    @(posedge clk);
    rd("R7 prescaled step", 1, 1);
    repeat (255) @(posedge clk);
    rd("R7 irq not yet", 3, 0);
    chk("R7 irq low", 32'(irq), 0);
    @(posedge clk);
    rd("R7 flag prescaled", 0, 32'h54E0);
    chk("R7 irq high", 32'(irq), 1);
    chk("R8 delayed", 32'(rst_req), 0);
    wr(0, 32'h4000);
    rd("R3 R7 flag cleared, cfg kept", 0, 32'h14E0);
    chk("R7 irq cleared", 32'(irq), 0);
    repeat (253) @(posedge clk);
    rd("R8 wait tick", 3, 0);
    chk("R8 before tick", 32'(rst_req), 0);
    @(posedge clk);
    rd("R8 at tick", 3, 0);
    chk("R8 after tick", 32'(rst_req), 1);

    // R9 freeze
    do_reset();
    wr(1, 32'hD928C520);
    wr(0, 32'h2000);
    wr(1, 32'hD928C520);
    rd("R9 frozen", 0, 32'h2400);

    // R10 service versus timeout
    do_reset();
    wr(1, 32'hD928C520);
    wr(2, 4);
    wr(0, 32'h20A0);
    repeat (3) @(posedge clk);
    wr(1, 32'hB480A602);
    rd("R10 count zero", 1, 0);
    rd("R10 no flag", 0, 32'h24A0);
    chk("R10 no reset", 32'(rst_req), 0);

    // R2 window length boundary
    do_reset();
    wr(1, 32'hD928C520);
    repeat (253) @(posedge clk);
    wr(2, 77);
    rd("R2 last window clock", 2, 77);
    wr(1, 32'hD928C520);
    repeat (254) @(posedge clk);
    wr(2, 88);
    rd("R2 window expired", 2, 77);
    rd("R2 closed status", 0, 32'h2020);

    finish_run();
  end
endmodule